// File: doc/BRIEF.md
# Watchdog Timer with Warm-Reset Control

This block is a watchdog for a processor module that sits on a shared backplane bus. A counter advances on every clock while software has the watchdog enabled. It stops at a programmable terminal value and raises a timeout event. Software keeps the counter away from that value by reading the status/control register, which acts as the service ("kick") operation. When it does, the counter restarts from zero.

The event is handled in one of two ways. When the interrupt-mask bit is set, the block is in interrupt mode. A timeout then raises a level interrupt and freezes the counter until software services it with a status read. Otherwise the block is in reset mode. A timeout then sets a latched timeout flag, requests a one-cycle warm reset and asserts a system-failure output. The warm reset keeps a few configuration bits and clears the rest, including the timeout flag. System-failure stays asserted until software reads the status/control register, or until power-on reset.

Register reads return data one cycle after the request. The returned value shows the state from before any clear that the read itself triggers.

Top module: `wdt_warm_top`

## Requirements
- R1: Counting: the counter starts at 0 and advances by one on each clock while the enable bit (control bit 1) is set. It holds at `termValue`, and the timeout event appears at the outputs exactly `termValue`+1 clocks after the write that sets the enable bit, or after the last status read.
- R2: In reset mode (mask clear), a timeout raises `warmRstOut` and the timeout flag (control bit 0) for exactly one cycle, and raises `sysFailOut` in the same cycle.
- R3: The warm reset clears the enable bit, the timeout flag, the interrupt-mask bit and configuration bits 3:0. It keeps configuration bits 7:4 and control bits 4 and 6.
- R4: `sysFailOut` stays high after the warm reset until a read of the status/control register (address 0). It drops in the cycle after that read.
- R5: In interrupt mode (mask = event bit 0 set, timeout flag clear), a timeout raises `irqOut` and clears the mask bit. It leaves `sysFailOut` and `warmRstOut` low.
- R6: While `irqOut` is high the counter is frozen: no further timeout occurs and `irqOut` stays high for as long as no status read arrives.
- R7: A status/control read lowers `irqOut` and reloads the counter to 0, after which counting resumes. Periodic reads keep any timeout from occurring.
- R8: Read data shows the state before the read's own clear. The status/control read layout is: bit7 system-failure, bit6 kept bit, bit5 interrupt pending, bit4 kept bit, bit1 enable, bit0 timeout flag, other bits 0. Address 1 reads the 8-bit configuration register and address 2 reads the mask in bit 0.
- R9: Power-on reset clears every register, including the kept bits and the system-failure state. All outputs are 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst | input | 1 | Power-on reset, active high, asynchronous |
| rdEn | input | 1 | Read request |
| rdAddr | input | 2 | Read address (0 status/control, 1 config, 2 event) |
| rdData | output | 8 | Registered read data |
| wrEn | input | 1 | Write request |
| wrAddr | input | 2 | Write address |
| wrData | input | 8 | Write data |
| termValue | input | CNT_W | Terminal count value |
| sysFailOut | output | 1 | System-failure output |
| irqOut | output | 1 | Level interrupt request |
| warmRstOut | output | 1 | One-cycle warm-reset request |

## Verification
The bench goes after the off-by-one in the timeout cycle, including a terminal value of 0. It looks for the warm reset clearing too many or too few bits: a wrong mask would show as corrupted high configuration bits or lost kept control bits. It checks that system-failure survives the warm reset, since a design that tied it to the timeout flag would drop it after one cycle. It checks that the interrupt-mode counter stays frozen, since a design that kept counting would raise a second event. The mask bit cleared by an interrupt-mode event must make the next timeout a warm reset, and the bench checks that status-read data shows the flags from before the read's own clear.

// File: rtl/wdt_warm_pkg.sv
package wdt_warm_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_EVT  = 2'd2;

  // status/control bit positions
  localparam int BIT_TO    = 0;
  localparam int BIT_EN    = 1;
  localparam int BIT_KEEPA = 4;
  localparam int BIT_IRQ   = 5;
  localparam int BIT_KEEPB = 6;
  localparam int BIT_FAIL  = 7;

  // configuration bits that survive a warm reset
  localparam logic [DATA_W-1:0] CFG_KEEP_MASK = 8'hF0;

  typedef struct packed {
    logic svcRead;
    logic warmClr;
  } dpStrobe_t;
endpackage

// File: rtl/wdt_warm_count.sv
module wdt_warm_count
  import wdt_warm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             porRst,
  input  logic             runEn,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] termValue,
  output logic             hit
);
  logic [CNT_W-1:0] count;
  logic             expired;
  logic             clrNow;

  assign clrNow = strobe.svcRead | strobe.warmClr;

  always_comb begin
    hit = runEn && !expired && (count == termValue) && !clrNow;
  end

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      count   <= '0;
      expired <= 1'b0;
    end else if (clrNow) begin
      count   <= '0;
      expired <= 1'b0;
    end else if (hit) begin
      expired <= 1'b1;
    end else if (runEn && !expired && count != termValue) begin
      count <= count + 1'b1;
    end
  end

  // R6: once expired, the count does not move until serviced
  a_r6_frozen: assert property (@(posedge clk) disable iff (porRst)
    (expired && !clrNow) |=> $stable(count));

  // R7: a service read reloads the counter
  a_r7_reload: assert property (@(posedge clk) disable iff (porRst)
    strobe.svcRead |=> (count == '0) && !expired);
endmodule

// File: rtl/wdt_warm_ctrl.sv
module wdt_warm_ctrl
  import wdt_warm_pkg::*;
(
  input  logic              clk,
  input  logic              porRst,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hit,
  output dpStrobe_t         strobe,
  output logic              runEn,
  output logic [DATA_W-1:0] rdData,
  output logic              sysFailOut,
  output logic              irqOut,
  output logic              warmRstOut
);
  logic              toFlag, ctrlEn, keepA, keepB, maskBit, sysFail, irqPend;
  logic [DATA_W-1:0] cfgReg, rdQ, rdMux, ctrlView;
  logic              irqMode, svcRead, warmClr;

  assign irqMode = maskBit && !toFlag;
  assign svcRead = rdEn && (rdAddr == ADDR_CTRL);
  assign warmClr = toFlag;

  assign strobe.svcRead = svcRead;
  assign strobe.warmClr = warmClr;
  assign runEn          = ctrlEn;

  always_comb begin
    ctrlView            = '0;
    ctrlView[BIT_TO]    = toFlag;
    ctrlView[BIT_EN]    = ctrlEn;
    ctrlView[BIT_KEEPA] = keepA;
    ctrlView[BIT_IRQ]   = irqPend;
    ctrlView[BIT_KEEPB] = keepB;
    ctrlView[BIT_FAIL]  = sysFail;
    case (rdAddr)
      ADDR_CTRL: rdMux = ctrlView;
      ADDR_CFG:  rdMux = cfgReg;
      ADDR_EVT:  rdMux = {{(DATA_W-1){1'b0}}, maskBit};
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      toFlag  <= 1'b0;
      ctrlEn  <= 1'b0;
      keepA   <= 1'b0;
      keepB   <= 1'b0;
      maskBit <= 1'b0;
      sysFail <= 1'b0;
      irqPend <= 1'b0;
      cfgReg  <= '0;
      rdQ     <= '0;
    end else begin
      if (warmClr) begin
        toFlag  <= 1'b0;
        ctrlEn  <= 1'b0;
        maskBit <= 1'b0;
        irqPend <= 1'b0;
        cfgReg  <= cfgReg & CFG_KEEP_MASK;
      end else begin
        if (wrEn) begin
          case (wrAddr)
            ADDR_CTRL: begin
              ctrlEn <= wrData[BIT_EN];
              keepA  <= wrData[BIT_KEEPA];
              keepB  <= wrData[BIT_KEEPB];
            end
            ADDR_CFG: cfgReg  <= wrData;
            ADDR_EVT: maskBit <= wrData[0];
            default: ;
          endcase
        end
        if (hit) begin
          if (irqMode) begin
            irqPend <= 1'b1;
            maskBit <= 1'b0;
          end else begin
            toFlag <= 1'b1;
          end
        end
        if (svcRead) irqPend <= 1'b0;
      end
      if (svcRead) sysFail <= 1'b0;
      else if (hit && !irqMode) sysFail <= 1'b1;
      if (rdEn) rdQ <= rdMux;
    end
  end

  assign rdData     = rdQ;
  assign sysFailOut = sysFail;
  assign irqOut     = irqPend;
  assign warmRstOut = toFlag;

  // R2: the warm-reset request lasts one cycle
  a_r2_warm_pulse: assert property (@(posedge clk) disable iff (porRst)
    warmRstOut |=> !warmRstOut);

  // R2: system-failure accompanies the warm-reset request
  a_r2_fail_with_warm: assert property (@(posedge clk) disable iff (porRst)
    warmRstOut |-> sysFailOut);

  // R3: kept configuration and control bits survive the warm reset
  a_r3_keep_bits: assert property (@(posedge clk) disable iff (porRst)
    warmClr |=> (cfgReg == ($past(cfgReg) & CFG_KEEP_MASK)) && $stable(keepA)
                && $stable(keepB) && !ctrlEn && !maskBit);

  // R4: system-failure is held until a status read
  a_r4_fail_hold: assert property (@(posedge clk) disable iff (porRst)
    (sysFailOut && !svcRead) |=> sysFailOut);

  // R5: an interrupt never coincides with a timeout-reset request
  a_r5_irq_not_reset: assert property (@(posedge clk) disable iff (porRst)
    irqOut |-> !warmRstOut);

  // R8: read data lags the request by one cycle and is unchanged otherwise
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (porRst)
    !rdEn |=> $stable(rdData));
endmodule

// File: rtl/wdt_warm_top.sv
module wdt_warm_top
  import wdt_warm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             porRst,
  input  logic             rdEn,
  input  logic [1:0]       rdAddr,
  output logic [7:0]       rdData,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [7:0]       wrData,
  input  logic [CNT_W-1:0] termValue,
  output logic             sysFailOut,
  output logic             irqOut,
  output logic             warmRstOut
);
  dpStrobe_t strobe;
  logic      hit;
  logic      runEn;

  wdt_warm_ctrl u_ctrl (
    .clk        (clk),
    .porRst     (porRst),
    .rdEn       (rdEn),
    .rdAddr     (rdAddr),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .hit        (hit),
    .strobe     (strobe),
    .runEn      (runEn),
    .rdData     (rdData),
    .sysFailOut (sysFailOut),
    .irqOut     (irqOut),
    .warmRstOut (warmRstOut)
  );

  wdt_warm_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .porRst    (porRst),
    .runEn     (runEn),
    .strobe    (strobe),
    .termValue (termValue),
    .hit       (hit)
  );
endmodule

// File: tb/tb_wdt_warm_top.sv
module tb_wdt_warm_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             porRst = 1'b1;
  logic             rdEn = 1'b0, wrEn = 1'b0;
  logic [1:0]       rdAddr = '0, wrAddr = '0;
  logic [7:0]       wrData = '0, rdData;
  logic [CNT_W-1:0] termValue = '0;
  logic             sysFailOut, irqOut, warmRstOut;

  int  nChecks = 0, nFails = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  wdt_warm_top #(.CNT_W(CNT_W)) dut (
    .clk(clk), .porRst(porRst), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .termValue(termValue),
    .sysFailOut(sysFailOut), .irqOut(irqOut), .warmRstOut(warmRstOut)
  );

  typedef struct packed {
    logic [15:0] term;
    logic        mask;
    logic [7:0]  cfg;
    logic [7:0]  ctrl;
    logic [7:0]  expCfg;
    logic [7:0]  expCtrl;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{16'd5, 1'b0, 8'hA5, 8'h52, 8'hA0, 8'hD0},
    '{16'd3, 1'b0, 8'h3C, 8'h02, 8'h30, 8'h80},
    '{16'd7, 1'b1, 8'h5A, 8'h12, 8'h5A, 8'h32},
    '{16'd1, 1'b1, 8'hFF, 8'h42, 8'hFF, 8'h62},
    '{16'd0, 1'b0, 8'h0F, 8'h12, 8'h00, 8'h90}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic por();
    porRst = 1'b1;
    repeat (2) @(negedge clk);
    porRst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    @(negedge clk);
    por();

    // R9: reset state
    chk("R9 outputs after por", {13'd0, sysFailOut, irqOut, warmRstOut}, 16'd0);
    rd(2'd0, d); chk("R9 ctrl after por", {8'd0, d}, 16'h0000);
    rd(2'd1, d); chk("R9 cfg after por", {8'd0, d}, 16'h0000);

    // table: one timeout per vector in the vector's mode
    for (int i = 0; i < NV; i++) begin
      termValue = VECS[i].term;
      por();
      wr(2'd1, VECS[i].cfg);
      wr(2'd2, {7'd0, VECS[i].mask});
      wr(2'd0, VECS[i].ctrl);
      repeat (int'(VECS[i].term)) @(negedge clk);
      chk("R1 no event before term+1", {13'd0, sysFailOut, irqOut, warmRstOut}, 16'd0);
      @(negedge clk);
      if (VECS[i].mask) begin
        chk("R5 irq at term+1", {13'd0, sysFailOut, irqOut, warmRstOut}, 16'b010);
      end else begin
        chk("R2 warm and fail at term+1", {13'd0, sysFailOut, irqOut, warmRstOut}, 16'b101);
      end
      @(negedge clk);
      if (VECS[i].mask) begin
        chk("R6 irq still pending", {15'd0, irqOut}, 16'd1);
      end else begin
        chk("R2 warm pulse one cycle, R4 fail held", {14'd0, sysFailOut, warmRstOut}, 16'b10);
      end
      rd(2'd1, d); chk("R3 cfg after event", {8'd0, d}, {8'd0, VECS[i].expCfg});
      rd(2'd2, d); chk("R5 R3 mask cleared", {8'd0, d}, 16'd0);
      rd(2'd0, d); chk("R8 ctrl read pre-clear", {8'd0, d}, {8'd0, VECS[i].expCtrl});
      chk("R4 R7 released by status read", {14'd0, sysFailOut, irqOut}, 16'd0);
    end

    // R9: por clears the bits a warm reset keeps
    por();
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'h50);
    por();
    rd(2'd1, d); chk("R9 kept cfg bits cleared by por", {8'd0, d}, 16'h0000);
    rd(2'd0, d); chk("R9 kept ctrl bits cleared by por", {8'd0, d}, 16'h0000);

    // R9: por drops a latched system-failure
    termValue = 16'd2;
    wr(2'd0, 8'h02);
    repeat (5) @(negedge clk);
    chk("R4 fail latched before por", {15'd0, sysFailOut}, 16'd1);
    por();
    chk("R9 fail cleared by por", {15'd0, sysFailOut}, 16'd0);

    // R7: periodic status reads prevent a timeout
    termValue = 16'd6;
    por();
    wr(2'd0, 8'h02);
    for (int k = 0; k < 5; k++) begin
      repeat (3) @(negedge clk);
      rd(2'd0, d);
      chk("R7 kicked, no event", {14'd0, sysFailOut, warmRstOut}, 16'd0);
    end
    repeat (6) @(negedge clk);
    chk("R1 R7 no event term cycles after kick", {15'd0, warmRstOut}, 16'd0);
    @(negedge clk);
    chk("R1 R7 event term+1 after kick", {15'd0, warmRstOut}, 16'd1);

    // R6/R7: interrupt freezes the counter, service re-arms in reset mode
    termValue = 16'd4;
    por();
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h02);
    repeat (5) @(negedge clk);
    chk("R5 irq raised", {15'd0, irqOut}, 16'd1);
    repeat (20) @(negedge clk);
    chk("R6 frozen, irq held, no reset", {14'd0, irqOut, warmRstOut}, 16'b10);
    rd(2'd0, d);
    chk("R8 service read shows pending", {8'd0, d}, 16'h0022);
    chk("R7 irq dropped after service", {15'd0, irqOut}, 16'd0);
    repeat (4) @(negedge clk);
    chk("R7 counting resumed, no event yet", {14'd0, irqOut, warmRstOut}, 16'd0);
    @(negedge clk);
    chk("R5 mask cleared so next event is reset", {13'd0, sysFailOut, irqOut, warmRstOut}, 16'b101);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule